// File: doc/BRIEF.md
# Broadcast Serial Oscillator Word Loader

This block drives a bank of phase-coherent direct digital synthesis channels from a single host request. It converts a frequency in hertz to a 32-bit tuning word by multiplying with a constant, not by dividing. It packs the tuning word with three zero control bits and a 5-bit phase value into a 40-bit frame. It then shifts that frame, least significant bit first, onto one data line that every channel shares. A word clock goes to every channel, and all the word clocks toggle in the same cycles. After the last bit, a frequency-update pulse makes the channels take the new word.

A request can also run a sweep. The block emits one frame for each step, from a start frequency up to a stop frequency, and waits a programmable dwell time between steps. It can issue a master reset pulse before the first frame, so that all channels start from a common phase. Only one request waits in the queue. A request that arrives while a run is active is held, and it starts when that run ends.

Top module: `dds_bcast_loader`

## Requirements
- R1: Each update pulse comes after exactly 40 word-clock rising edges, with no other rising edge between the previous update pulse and this one.
- R2: The bits of a frame are sent least significant first. Frame bits 0..31 hold floor(f * 2^32 / REF_HZ), where REF_HZ defaults to 125000000. Bits 32..34 are zero. Bits 35..39 hold the phase value.
- R3: All NUM_CH word-clock outputs carry the same value in every cycle, and one data output serves every channel.
- R4: Each word-clock high phase lasts exactly `wclk_hi_i` cycles. Each low phase before a rising edge lasts at least `wclk_lo_i` cycles. The data line does not change on the clock edge where the word clock rises.
- R5: After the 40th bit, the update output goes high for exactly `wclk_hi_i` cycles, and the word clocks stay low during that time.
- R6: `busy_o` goes high from the start of a frame until the update pulse ends. It falls on the same clock edge as the update output.
- R7: When `reset_en_i` is set, a master reset pulse of RST_CYC cycles (default 4) comes before the first frame of the run. No frame activity occurs during the pulse.
- R8: A run emits frames for start, start+step, and so on, up to the largest value that is not above the stop value. A step of zero, or a start value at or above the stop value, produces exactly one frame.
- R9: Between the end of one update pulse and the first word-clock rise of the next frame in a sweep, at least `dwell_i` cycles pass.
- R10: A request that arrives while a run is active is held and runs after the active run, and `run_o` stays high throughout.
- R11: While reset is applied, all outputs are low. They stay low until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| start_hz_i | input | 32 | First frequency in Hz |
| stop_hz_i | input | 32 | Last allowed frequency in Hz |
| step_hz_i | input | 32 | Sweep increment in Hz (0 = single frame) |
| phase_i | input | 5 | Phase value for all frames of the run |
| dwell_i | input | 16 | Minimum cycles between frames of a sweep |
| reset_en_i | input | 1 | Issue master reset before the run |
| wclk_hi_i | input | 4 | Word-clock and update high time, cycles (>=1) |
| wclk_lo_i | input | 4 | Word-clock low time, cycles (>=1) |
| dds_data_o | output | 1 | Shared serial data line |
| dds_wclk_o | output | NUM_CH | Word clock, one per channel |
| dds_fqud_o | output | 1 | Frequency-update latch pulse |
| dds_reset_o | output | 1 | Master reset pulse |
| busy_o | output | 1 | Frame in progress |
| run_o | output | 1 | Run active or request pending |

## Verification
The assertions assume three things about the inputs. `wclk_hi_i` and `wclk_lo_i` are at least one. The timing inputs do not change while `run_o` is high. REF_HZ is below 2^32, which keeps the constant multiply exact. The stimulus changes the timing inputs only when the block is idle and always uses values of one or more. A held request carries its own copy of every field. The bench therefore changes the request inputs freely once a strobe has been given.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;
  localparam int FREQ_W  = 32;
  localparam int CTRL_W  = 3;
  localparam int PHASE_W = 5;
  localparam int FRAME_W = FREQ_W + CTRL_W + PHASE_W;
  localparam int DWELL_W = 16;

  typedef struct packed {
    logic [FREQ_W-1:0]  start_hz;
    logic [FREQ_W-1:0]  stop_hz;
    logic [FREQ_W-1:0]  step_hz;
    logic [PHASE_W-1:0] phase;
    logic [DWELL_W-1:0] dwell;
    logic               rst_en;
  } sweep_req_t;

  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH, SH_UPD} shift_st_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_RST, SQ_GAP, SQ_LOAD, SQ_WAIT, SQ_DWELL} seq_st_e;
endpackage

// File: rtl/dds_tuning_calc.sv
module dds_tuning_calc #(
  parameter int FREQ_W = 32,
  parameter int REF_HZ = 125_000_000
) (
  input  logic [FREQ_W-1:0] hz_i,
  output logic [FREQ_W-1:0] word_o
);
  // extra fraction bits keep ceil(2^(F+SH)/REF) * hz exact after flooring
  localparam int SH = 2 * FREQ_W;
  localparam int PW = FREQ_W + SH + 1;
  localparam int MW = FREQ_W + PW;
  localparam logic [PW-1:0] ONE = PW'(1);
  localparam logic [PW-1:0] K   = ((ONE << (FREQ_W + SH)) + PW'(REF_HZ - 1)) / PW'(REF_HZ);

  logic [MW-1:0] prod;
  assign prod   = MW'(hz_i) * MW'(K);
  assign word_o = FREQ_W'(prod >> SH);
endmodule

// File: rtl/dds_frame_shifter.sv
module dds_frame_shifter
  import dds_ldr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   hi_i,
  input  logic [CNT_W-1:0]   lo_i,
  output logic               data_o,
  output logic               wclk_o,
  output logic               fqud_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int BC_W = $clog2(FRAME_W);

  shift_st_e          st;
  logic [FRAME_W-1:0] sr;
  logic [BC_W-1:0]    bit_cnt;
  logic [CNT_W-1:0]   cnt;
  logic               last;

  assign busy_o = (st != SH_IDLE);
  assign done_o = (st == SH_UPD) && (cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= SH_IDLE; sr <= '0; bit_cnt <= '0; cnt <= '0; last <= 1'b0;
      data_o <= 1'b0; wclk_o <= 1'b0; fqud_o <= 1'b0;
    end else begin
      case (st)
        SH_IDLE: if (load_i) begin
          sr      <= frame_i;
          data_o  <= frame_i[0];
          bit_cnt <= '0;
          last    <= 1'b0;
          cnt     <= lo_i - CNT_W'(1);
          st      <= SH_LOW;
        end
        SH_LOW: begin
          if (cnt == '0) begin
            cnt <= hi_i - CNT_W'(1);
            if (last) begin
              fqud_o <= 1'b1;
              st     <= SH_UPD;
            end else begin
              wclk_o <= 1'b1;
              st     <= SH_HIGH;
            end
          end else cnt <= cnt - CNT_W'(1);
        end
        SH_HIGH: begin
          if (cnt == '0) begin
            wclk_o <= 1'b0;
            cnt    <= lo_i - CNT_W'(1);
            st     <= SH_LOW;
            if (bit_cnt == BC_W'(FRAME_W - 1)) last <= 1'b1;
            else begin
              bit_cnt <= bit_cnt + BC_W'(1);
              sr      <= sr >> 1;
              data_o  <= sr[1];
            end
          end else cnt <= cnt - CNT_W'(1);
        end
        SH_UPD: begin
          if (cnt == '0) begin
            fqud_o <= 1'b0;
            st     <= SH_IDLE;
          end else cnt <= cnt - CNT_W'(1);
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dds_sweep_seq.sv
module dds_sweep_seq
  import dds_ldr_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  sweep_req_t         req_i,
  input  logic               done_i,
  output logic               load_o,
  output logic [FREQ_W-1:0]  cur_hz_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               reset_o,
  output logic               run_o
);
  seq_st_e            st;
  sweep_req_t         pend_req, sel;
  logic               pend;
  logic [FREQ_W-1:0]  cur, stop_q, step_q;
  logic [DWELL_W-1:0] dwell_q, cnt;
  logic               last;

  assign sel      = pend ? pend_req : req_i;
  assign last     = (step_q == '0) || (({1'b0, cur} + {1'b0, step_q}) > {1'b0, stop_q});
  assign load_o   = (st == SQ_LOAD);
  assign cur_hz_o = cur;
  assign run_o    = (st != SQ_IDLE) || pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= SQ_IDLE; pend <= 1'b0; pend_req <= '0; cur <= '0; stop_q <= '0;
      step_q <= '0; dwell_q <= '0; phase_o <= '0; cnt <= '0; reset_o <= 1'b0;
    end else begin
      // one-deep hold queue; a newer request replaces a waiting one
      if (start_i && !(st == SQ_IDLE && !pend)) begin
        pend     <= 1'b1;
        pend_req <= req_i;
      end else if (st == SQ_IDLE && pend) pend <= 1'b0;

      case (st)
        SQ_IDLE: if (pend || start_i) begin
          cur     <= sel.start_hz;
          stop_q  <= sel.stop_hz;
          step_q  <= sel.step_hz;
          dwell_q <= sel.dwell;
          phase_o <= sel.phase;
          if (sel.rst_en) begin
            reset_o <= 1'b1;
            cnt     <= DWELL_W'(RST_CYC - 1);
            st      <= SQ_RST;
          end else st <= SQ_LOAD;
        end
        SQ_RST: if (cnt == '0) begin
          reset_o <= 1'b0;
          cnt     <= DWELL_W'(RST_CYC - 1);
          st      <= SQ_GAP;
        end else cnt <= cnt - DWELL_W'(1);
        SQ_GAP: if (cnt == '0) st <= SQ_LOAD;
                else cnt <= cnt - DWELL_W'(1);
        SQ_LOAD: st <= SQ_WAIT;
        SQ_WAIT: if (done_i) begin
          if (last) st <= SQ_IDLE;
          else begin
            cnt <= dwell_q;
            st  <= SQ_DWELL;
          end
        end
        SQ_DWELL: if (cnt == '0) begin
          cur <= cur + step_q;
          st  <= SQ_LOAD;
        end else cnt <= cnt - DWELL_W'(1);
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dds_bcast_loader.sv
module dds_bcast_loader
  import dds_ldr_pkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int REF_HZ  = 125_000_000,
  parameter int RST_CYC = 4,
  parameter int CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FREQ_W-1:0]  start_hz_i,
  input  logic [FREQ_W-1:0]  stop_hz_i,
  input  logic [FREQ_W-1:0]  step_hz_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic               reset_en_i,
  input  logic [CNT_W-1:0]   wclk_hi_i,
  input  logic [CNT_W-1:0]   wclk_lo_i,
  output logic               dds_data_o,
  output logic [NUM_CH-1:0]  dds_wclk_o,
  output logic               dds_fqud_o,
  output logic               dds_reset_o,
  output logic               busy_o,
  output logic               run_o
);
  sweep_req_t         req;
  logic               load, done, wclk;
  logic [FREQ_W-1:0]  cur_hz, word;
  logic [PHASE_W-1:0] phase;
  logic [FRAME_W-1:0] frame;

  assign req = '{start_hz: start_hz_i, stop_hz: stop_hz_i, step_hz: step_hz_i,
                 phase: phase_i, dwell: dwell_i, rst_en: reset_en_i};

  dds_sweep_seq #(.RST_CYC(RST_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .req_i(req), .done_i(done),
    .load_o(load), .cur_hz_o(cur_hz), .phase_o(phase), .reset_o(dds_reset_o), .run_o(run_o)
  );

  dds_tuning_calc #(.FREQ_W(FREQ_W), .REF_HZ(REF_HZ)) u_calc (.hz_i(cur_hz), .word_o(word));

  assign frame = {phase, CTRL_W'(0), word};

  dds_frame_shifter #(.CNT_W(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .frame_i(frame),
    .hi_i(wclk_hi_i), .lo_i(wclk_lo_i), .data_o(dds_data_o), .wclk_o(wclk),
    .fqud_o(dds_fqud_o), .busy_o(busy_o), .done_o(done)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_wclk
    assign dds_wclk_o[c] = wclk;
  end
endmodule

// File: rtl/dds_ldr_chk.sv
module dds_ldr_chk #(
  parameter int NUM_CH  = 5,
  parameter int FRAME_W = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dds_data_o,
  input logic [NUM_CH-1:0] dds_wclk_o,
  input logic              dds_fqud_o,
  input logic              dds_reset_o,
  input logic              busy_o,
  input logic              run_o
);
  localparam int RC_W = $clog2(FRAME_W) + 2;
  logic [RC_W-1:0] rise_cnt;
  logic            wclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt <= '0; wclk_q <= 1'b0;
    end else begin
      wclk_q <= dds_wclk_o[0];
      if (dds_fqud_o) rise_cnt <= '0;
      else if (dds_wclk_o[0] && !wclk_q) rise_cnt <= rise_cnt + RC_W'(1);
    end
  end

  // R1
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dds_fqud_o) |-> rise_cnt == RC_W'(FRAME_W));
  // R4
  data_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dds_wclk_o[0]) |-> $stable(dds_data_o));
  // R5
  upd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dds_fqud_o |-> dds_wclk_o == '0);
  // R6
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dds_fqud_o || dds_wclk_o != '0) |-> busy_o);
  // R6
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dds_fqud_o) |-> !busy_o);
  // R7
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dds_reset_o |-> !busy_o);
  // R10
  run_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o || dds_reset_o) |-> run_o);
endmodule

bind dds_bcast_loader dds_ldr_chk #(.NUM_CH(NUM_CH), .FRAME_W(dds_ldr_pkg::FRAME_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dds_data_o(dds_data_o), .dds_wclk_o(dds_wclk_o),
  .dds_fqud_o(dds_fqud_o), .dds_reset_o(dds_reset_o), .busy_o(busy_o), .run_o(run_o)
);

// File: tb/sim_dds_bcast_loader.sv
module sim_dds_bcast_loader;
  localparam int NCH = 5;
  localparam longint unsigned REF = 125_000_000;
  localparam int RST = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rst_en = 1'b0;
  logic [31:0] f_start = '0, f_stop = '0, f_step = '0;
  logic [4:0] ph = '0;
  logic [15:0] dwell = '0;
  logic [3:0] hi = 4'd1, lo = 4'd1;
  logic data, fqud, ddsrst, busy, run;
  logic [NCH-1:0] wclk;

  dds_bcast_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_hz_i(f_start), .stop_hz_i(f_stop),
    .step_hz_i(f_step), .phase_i(ph), .dwell_i(dwell), .reset_en_i(rst_en),
    .wclk_hi_i(hi), .wclk_lo_i(lo), .dds_data_o(data), .dds_wclk_o(wclk),
    .dds_fqud_o(fqud), .dds_reset_o(ddsrst), .busy_o(busy), .run_o(run)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_frame(input longint unsigned f, input logic [4:0] p);
    longint unsigned w = (f << 32) / REF;
    return {p, 3'b000, w[31:0]};
  endfunction

  // serial capture monitor
  logic [39:0] cap [64];
  int gaps [64];
  int ncap = 0, bits = 0, cyc = 0, fall_cyc = 0;
  int hi_len = 0, lo_len = 0, fq_len = 0, rst_len = 0, rst_ncap = -1;
  logic [39:0] sh = '0;
  logic p_w = 0, p_f = 0, p_d = 0, p_r = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!(wclk == '0 || wclk == '1)) chk(0, "R3 wclk mismatch", wclk, 0);
      if (wclk[0] && !p_w) begin
        if (bits == 0) gaps[ncap] = cyc - fall_cyc;
        chk(lo_len >= lo, "R4 low phase", lo_len, lo);
        chk(data == p_d, "R4 data setup", data, p_d);
        chk(busy, "R6 busy at wclk", busy, 1);
        sh = {data, sh[39:1]};
        bits++;
        hi_len = 0;
      end
      if (!wclk[0] && p_w) begin
        chk(hi_len == hi, "R4 high phase", hi_len, hi);
        lo_len = 0;
      end
      if (wclk[0]) hi_len++;
      else if (busy && !fqud) lo_len++;
      if (fqud && !p_f) begin
        chk(bits == 40, "R1 bits per frame", bits, 40);
        chk(wclk == '0, "R5 wclk low in update", wclk, 0);
        cap[ncap] = sh; ncap++; bits = 0; fq_len = 0;
      end
      if (fqud) fq_len++;
      if (!fqud && p_f) begin
        chk(fq_len == hi, "R5 update width", fq_len, hi);
        chk(!busy, "R6 busy ends with update", busy, 0);
        fall_cyc = cyc; lo_len = 0;
      end
      if (ddsrst) begin
        rst_len++;
        if (busy || wclk != '0) chk(0, "R7 activity during reset", busy, 0);
      end
      if (!ddsrst && p_r) begin
        chk(rst_len == RST, "R7 reset width", rst_len, RST);
        rst_ncap = ncap; rst_len = 0;
      end
    end
    p_w = wclk[0]; p_f = fqud; p_d = data; p_r = ddsrst;
  end

  task automatic send(input longint unsigned a, input longint unsigned b, input longint unsigned s,
                      input logic [4:0] p, input int dw, input bit re);
    @(negedge clk);
    f_start = a[31:0]; f_stop = b[31:0]; f_step = s[31:0]; ph = p; dwell = dw[15:0]; rst_en = re;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (run || busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(data == 0 && wclk == '0 && fqud == 0 && ddsrst == 0, "R11 outputs in reset", {data, fqud, ddsrst}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy == 0 && run == 0 && wclk == '0, "R11 idle after reset", {busy, run}, 0);
  endtask

  task automatic t_single();
    int b = ncap;
    hi = 4'd2; lo = 4'd1;
    send(1_000_000, 1_000_000, 0, 5'd7, 0, 0);
    wait_idle();
    chk(ncap - b == 1, "R8 single frame", ncap - b, 1);
    chk(cap[b] == exp_frame(1_000_000, 5'd7), "R2 frame 1MHz", cap[b], exp_frame(1_000_000, 5'd7));
    chk(cap[b][34:32] == 3'b000, "R2 control bits", cap[b][34:32], 0);
  endtask

  task automatic t_timing();
    int b = ncap;
    hi = 4'd3; lo = 4'd2;
    send(3_000_000, 0, 10_000, 5'd31, 0, 0);
    wait_idle();
    chk(ncap - b == 1, "R8 start above stop", ncap - b, 1);
    chk(cap[b] == exp_frame(3_000_000, 5'd31), "R2 frame 3MHz phase 31", cap[b], exp_frame(3_000_000, 5'd31));
  endtask

  task automatic t_sweep_reset();
    int b = ncap;
    hi = 4'd1; lo = 4'd1;
    send(10_000, 50_000, 10_000, 5'd12, 20, 1);
    wait_idle();
    chk(rst_ncap == b, "R7 reset before first frame", rst_ncap, b);
    chk(ncap - b == 5, "R8 sweep count", ncap - b, 5);
    for (int k = 0; k < 5; k++) begin
      chk(cap[b+k] == exp_frame(10_000 * (k + 1), 5'd12), "R8 sweep step frame",
          cap[b+k], exp_frame(10_000 * (k + 1), 5'd12));
      if (k > 0) chk(gaps[b+k] >= 20, "R9 dwell gap", gaps[b+k], 20);
    end
  endtask

  task automatic t_partial();
    int b = ncap;
    hi = 4'd1; lo = 4'd2;
    send(10_000, 35_000, 10_000, 5'd1, 3, 0);
    wait_idle();
    chk(ncap - b == 3, "R8 stop not on step", ncap - b, 3);
    chk(cap[b+2] == exp_frame(30_000, 5'd1), "R8 last step", cap[b+2], exp_frame(30_000, 5'd1));
  endtask

  task automatic t_hold();
    int b = ncap;
    hi = 4'd1; lo = 4'd1;
    send(10_000, 30_000, 10_000, 5'd4, 10, 0);
    do @(negedge clk); while (!busy);
    send(777_000, 777_000, 0, 5'd3, 0, 0);
    chk(run, "R10 run held", run, 1);
    wait_idle();
    chk(ncap - b == 4, "R10 frames after held request", ncap - b, 4);
    chk(cap[b+2] == exp_frame(30_000, 5'd4), "R10 active run completes", cap[b+2], exp_frame(30_000, 5'd4));
    chk(cap[b+3] == exp_frame(777_000, 5'd3), "R10 held request last", cap[b+3], exp_frame(777_000, 5'd3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_timing();
    t_sweep_reset();
    t_partial();
    t_hold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule